// File: doc/BRIEF.md
# Fractional Ratio Tick Divider

This block turns one of several base-rate strobes into a slower enable pulse stream for a serial bus controller. The whole block runs on a single clock. Each base rate reaches it as a one-cycle strobe. A select input picks which strobe drives a counter. A 5-bit ratio code sets how many selected strobes make up one output period. Seven ratios are available: 2, 2.5, 3, 4, 5, 6 and 8. The 2.5 ratio has no whole-number period, so the block produces it by alternating periods of 2 and 3 strobes.

The ratio code is split into two parts. The upper three bits choose a fractional or odd ratio. When those upper bits are zero, the lower two bits choose among the power-of-two ratios. Codes with no defined meaning fall back to divide-by-2 and raise an error flag. The output stops when the low-power input is high. It also stops in wait mode, unless the keep-running-in-wait control is set. A new ratio or source is taken only at the end of the current period, so no period is ever cut short or stretched by the change.

Top module: `bus_tick_divider`

## Requirements
- R1: With ratio_code[4:2]=000, ratio_code[1:0]=00 emits one pulse every 2 selected strobes, 01 every 4 and 10 every 8.
- R2: ratio_code[4:2]=001 alternates periods of 2 and 3 strobes, starting with 2 after reset or after switching into this ratio. The codes 010, 011 and 100 give 3, 5 and 6 strobes. For all four, ratio_code[1:0] has no effect.
- R3: The undefined codes (00011, and any code with ratio_code[4:2] of 101, 110 or 111) divide by 2 and set cfg_err to 1. Any defined code gives cfg_err 0. cfg_err describes the code currently in force.
- R4: Only strobes on src_tick[src_sel] advance the divider. src_sel=0 selects bit 0 and src_sel=1 selects bit 1. Strobes on the other input have no effect.
- R5: tick_out goes high for exactly one cycle, in the cycle after the clock edge that samples the strobe completing a period. Two pulses are never adjacent.
- R6: While lowpower is 1, strobes are ignored. No pulse is emitted and the count and phase are held, so counting resumes where it stopped.
- R7: While wait_mode is 1 and run_in_wait is 0, the divider halts in the same way as R6. With run_in_wait at 1, wait_mode has no effect.
- R8: ratio_code and src_sel are loaded into the working configuration only at the edge that completes a period, and at reset. A change in between has no effect on the current period.
- R9: A synchronous active-high rst clears tick_out, zeroes the count and phase, and loads the present ratio_code and src_sel. The first pulse then follows one full period of strobes later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| src_tick | input | SRC_COUNT | Base-rate strobes, one per source |
| src_sel | input | SEL_W | Index of the source strobe to divide |
| ratio_code | input | 5 | Ratio select code (upper 3 bits plus lower 2 bits) |
| lowpower | input | 1 | Stop or low-power mode: halts the divider |
| wait_mode | input | 1 | Wait mode indicator |
| run_in_wait | input | 1 | 1 = keep dividing during wait mode |
| tick_out | output | 1 | One-cycle enable pulse at the divided rate |
| cfg_err | output | 1 | The ratio code in force is undefined |

## Verification
The bench uses the default SRC_COUNT of 2, which makes SEL_W 1. This lets random strobe patterns on both sources drive the block while src_sel switches between them mid-period. The 3-bit count then reaches its top value of 7 under divide-by-8. That covers the widest period, as well as the 2-then-3 alternation and the reset of the phase when the block switches into or out of the 2.5 ratio. Random halts, random wait settings and frequent code changes test the hold behaviour and the rule that changes load only at a period boundary.

// File: rtl/tickdiv_pkg.sv
`timescale 1ns/1ps
package tickdiv_pkg;

    localparam int CODE_W = 5;
    localparam int CNT_W  = 3;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [2:0] {
        RT_2   = 3'd0,
        RT_2P5 = 3'd1,
        RT_3   = 3'd2,
        RT_4   = 3'd3,
        RT_5   = 3'd4,
        RT_6   = 3'd5,
        RT_8   = 3'd6
    } ratio_e;

    typedef struct packed {
        ratio_e ratio;
        logic   bad;
    } ratio_dec_t;

    // Split decode: the upper field picks fractional/odd ratios,
    // the low field is consulted only when the upper field is zero.
    function automatic ratio_dec_t decode_code(input code_t c);
        ratio_dec_t d;
        d.ratio = RT_2;
        d.bad   = 1'b0;
        case (c[4:2])
            3'b000: begin
                case (c[1:0])
                    2'b00:   d.ratio = RT_2;
                    2'b01:   d.ratio = RT_4;
                    2'b10:   d.ratio = RT_8;
                    default: d.bad   = 1'b1;
                endcase
            end
            3'b001:  d.ratio = RT_2P5;
            3'b010:  d.ratio = RT_3;
            3'b011:  d.ratio = RT_5;
            3'b100:  d.ratio = RT_6;
            default: d.bad   = 1'b1;
        endcase
        return d;
    endfunction

    // Terminal count (period minus one); the half ratio uses the phase bit.
    function automatic cnt_t period_last(input ratio_e r, input logic phase);
        cnt_t v;
        case (r)
            RT_2:    v = cnt_t'(1);
            RT_2P5:  v = phase ? cnt_t'(2) : cnt_t'(1);
            RT_3:    v = cnt_t'(2);
            RT_4:    v = cnt_t'(3);
            RT_5:    v = cnt_t'(4);
            RT_6:    v = cnt_t'(5);
            RT_8:    v = cnt_t'(7);
            default: v = cnt_t'(1);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/tickdiv_decode.sv
`timescale 1ns/1ps
module tickdiv_decode
    import tickdiv_pkg::*;
(
    input  code_t      code,
    output ratio_dec_t dec
);
    always_comb begin
        dec = decode_code(code);
    end
endmodule

// File: rtl/tickdiv_source.sv
`timescale 1ns/1ps
module tickdiv_source #(
    parameter int SRC_COUNT = 2,
    parameter int SEL_W     = 1
) (
    input  logic [SRC_COUNT-1:0] src_tick,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 lowpower,
    input  logic                 wait_mode,
    input  logic                 run_in_wait,
    output logic                 strobe,
    output logic                 halt
);
    logic [SRC_COUNT-1:0] hit;

    for (genvar i = 0; i < SRC_COUNT; i++) begin : g_src
        assign hit[i] = src_tick[i] && (sel == SEL_W'(i));
    end

    assign strobe = |hit;
    assign halt   = lowpower || (wait_mode && !run_in_wait);
endmodule

// File: rtl/tickdiv_core.sv
`timescale 1ns/1ps
module tickdiv_core
    import tickdiv_pkg::*;
#(
    parameter int SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             halt,
    input  ratio_dec_t       req_dec,
    input  logic [SEL_W-1:0] req_sel,
    output logic [SEL_W-1:0] act_sel,
    output ratio_e           act_ratio,
    output cnt_t             cnt,
    output logic             tick_out,
    output logic             cfg_err
);
    logic phase;
    logic act_bad;
    cnt_t last;
    logic advance;
    logic wrap;

    assign last    = period_last(act_ratio, phase);
    assign advance = strobe && !halt;
    assign wrap    = advance && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            phase     <= 1'b0;
            act_ratio <= req_dec.ratio;
            act_bad   <= req_dec.bad;
            act_sel   <= req_sel;
            tick_out  <= 1'b0;
        end else begin
            tick_out <= wrap;
            if (wrap) begin
                cnt       <= '0;
                act_ratio <= req_dec.ratio;
                act_bad   <= req_dec.bad;
                act_sel   <= req_sel;
                phase     <= (req_dec.ratio == RT_2P5 && act_ratio == RT_2P5) ? !phase : 1'b0;
            end else if (advance) begin
                cnt <= cnt + cnt_t'(1);
            end
        end
    end

    assign cfg_err = act_bad;
endmodule

// File: rtl/bus_tick_divider.sv
`timescale 1ns/1ps
module bus_tick_divider
    import tickdiv_pkg::*;
#(
    parameter int SRC_COUNT = 2,
    parameter int SEL_W     = (SRC_COUNT > 1) ? $clog2(SRC_COUNT) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SRC_COUNT-1:0] src_tick,
    input  logic [SEL_W-1:0]     src_sel,
    input  logic [CODE_W-1:0]    ratio_code,
    input  logic                 lowpower,
    input  logic                 wait_mode,
    input  logic                 run_in_wait,
    output logic                 tick_out,
    output logic                 cfg_err
);
    ratio_dec_t       req_dec;
    logic [SEL_W-1:0] act_sel;
    ratio_e           act_ratio_w;
    cnt_t             cnt_w;
    logic             sel_strobe;
    logic             halted;

    tickdiv_decode u_dec (
        .code (ratio_code),
        .dec  (req_dec)
    );

    tickdiv_source #(.SRC_COUNT(SRC_COUNT), .SEL_W(SEL_W)) u_src (
        .src_tick    (src_tick),
        .sel         (act_sel),
        .lowpower    (lowpower),
        .wait_mode   (wait_mode),
        .run_in_wait (run_in_wait),
        .strobe      (sel_strobe),
        .halt        (halted)
    );

    tickdiv_core #(.SEL_W(SEL_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .strobe    (sel_strobe),
        .halt      (halted),
        .req_dec   (req_dec),
        .req_sel   (src_sel),
        .act_sel   (act_sel),
        .act_ratio (act_ratio_w),
        .cnt       (cnt_w),
        .tick_out  (tick_out),
        .cfg_err   (cfg_err)
    );
endmodule

module bus_tick_divider_chk
    import tickdiv_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   tick_out,
    input logic   cfg_err,
    input logic   strobe,
    input logic   halt,
    input ratio_e act_ratio,
    input cnt_t   cnt
);
    // R5: pulses never adjacent
    a_r5_no_adjacent: assert property (@(posedge clk) disable iff (rst)
        tick_out |=> !tick_out);

    // R6/R7: a halted cycle never produces a pulse
    a_r6_halt_blocks: assert property (@(posedge clk) disable iff (rst)
        $past(halt) |-> !tick_out);

    // R4: a pulse requires a selected strobe in the previous cycle
    a_r4_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        !$past(strobe) |-> !tick_out);

    // R8: the working ratio only changes together with a pulse
    a_r8_boundary_load: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && act_ratio != $past(act_ratio)) |-> tick_out);

    // R3: an undefined code always runs as divide-by-2
    a_r3_err_div2: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> act_ratio == RT_2);

    // R1: the count stays within the longest period of the working ratio
    a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= period_last(act_ratio, 1'b1));
endmodule

bind bus_tick_divider bus_tick_divider_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_out  (tick_out),
    .cfg_err   (cfg_err),
    .strobe    (sel_strobe),
    .halt      (halted),
    .act_ratio (act_ratio_w),
    .cnt       (cnt_w)
);

// File: tb/bus_tick_divider_test.sv
`timescale 1ns/1ps
module bus_tick_divider_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] src_tick = '0;
    logic [0:0] src_sel = '0;
    logic [4:0] ratio_code = '0;
    logic       lowpower = 1'b0;
    logic       wait_mode = 1'b0;
    logic       run_in_wait = 1'b0;
    logic       tick_out;
    logic       cfg_err;

    always #2.5 clk = ~clk;

    bus_tick_divider uut (
        .clk         (clk),
        .rst         (rst),
        .src_tick    (src_tick),
        .src_sel     (src_sel),
        .ratio_code  (ratio_code),
        .lowpower    (lowpower),
        .wait_mode   (wait_mode),
        .run_in_wait (run_in_wait),
        .tick_out    (tick_out),
        .cfg_err     (cfg_err)
    );

    typedef struct {
        logic  t;
        logic  e;
        string req;
    } exp_t;

    exp_t  sb[$];
    int    n_vec  = 0;
    int    n_fail = 0;
    string cur_req = "R9";
    bit    done = 0;

    // independent reference state
    int m_cnt, m_r2, m_phase, m_sel;
    bit m_err;

    // ratio times two, from the requirement table
    function automatic int ref_r2(input logic [4:0] c);
        case (c[4:2])
            3'd0: case (c[1:0])
                      2'd0: return 4;
                      2'd1: return 8;
                      2'd2: return 16;
                      default: return 4;
                  endcase
            3'd1: return 5;
            3'd2: return 6;
            3'd3: return 10;
            3'd4: return 12;
            default: return 4;
        endcase
    endfunction

    function automatic bit ref_bad(input logic [4:0] c);
        return (c == 5'b00011) || (c[4:2] > 3'd4);
    endfunction

    task automatic step(input logic [1:0] tk, input logic lp, input logic wm, input logic rw);
        exp_t x;
        bit   strb, hlt, t;
        int   last, nr;
        src_tick = tk; lowpower = lp; wait_mode = wm; run_in_wait = rw;
        strb = tk[m_sel];
        hlt  = lp || (wm && !rw);
        t    = 0;
        if (strb && !hlt) begin
            last = (m_r2 == 5) ? (m_phase ? 2 : 1) : (m_r2 / 2 - 1);
            if (m_cnt == last) begin
                t = 1;
                m_cnt = 0;
                nr = ref_r2(ratio_code);
                m_phase = (nr == 5 && m_r2 == 5) ? 1 - m_phase : 0;
                m_r2 = nr;
                m_err = ref_bad(ratio_code);
                m_sel = int'(src_sel);
            end else begin
                m_cnt++;
            end
        end
        x.t = t; x.e = m_err; x.req = cur_req;
        sb.push_back(x);
        @(negedge clk);
    endtask

    // monitor: compare one item per clock after the edge has settled
    always @(posedge clk) begin
        exp_t x;
        #1;
        if (sb.size() > 0) begin
            x = sb.pop_front();
            n_vec++;
            if (tick_out !== x.t || cfg_err !== x.e) begin
                n_fail++;
                $display("FAIL %s: tick_out=%b cfg_err=%b, expected tick_out=%b cfg_err=%b",
                         x.req, tick_out, cfg_err, x.t, x.e);
            end
        end
    end

    task automatic do_reset(input logic [4:0] c, input logic s);
        wait (sb.size() == 0);
        @(negedge clk);
        rst = 1'b1; ratio_code = c; src_sel = s; src_tick = '0;
        lowpower = 0; wait_mode = 0; run_in_wait = 0;
        @(negedge clk);
        @(negedge clk);
        n_vec++;
        if (tick_out !== 1'b0 || cfg_err !== ref_bad(c)) begin
            n_fail++;
            $display("FAIL R9: reset tick_out=%b cfg_err=%b, expected 0 %b",
                     tick_out, cfg_err, ref_bad(c));
        end
        m_cnt = 0; m_phase = 0; m_r2 = ref_r2(c); m_err = ref_bad(c); m_sel = int'(s);
        rst = 1'b0;
    endtask

    task automatic run_steady(input logic [4:0] c, input int n);
        ratio_code = c;
        for (int i = 0; i < n; i++) step(2'b11, 0, 0, 0);
    endtask

    initial begin
        logic [4:0] legal [9];
        legal = '{5'b00000, 5'b00001, 5'b00010, 5'b00100, 5'b01001,
                  5'b01010, 5'b01111, 5'b10000, 5'b00110};

        cur_req = "R9";
        do_reset(5'b00000, 1'b0);
        cur_req = "R1";
        run_steady(5'b00000, 20);
        run_steady(5'b00001, 40);
        run_steady(5'b00010, 48);
        run_steady(5'b00000, 10);

        cur_req = "R2";
        run_steady(5'b00100, 30);
        run_steady(5'b00111, 30);
        run_steady(5'b01000, 30);
        run_steady(5'b01010, 30);
        run_steady(5'b01100, 40);
        run_steady(5'b01111, 40);
        run_steady(5'b10000, 40);
        run_steady(5'b10011, 40);
        run_steady(5'b00101, 30);

        cur_req = "R3";
        run_steady(5'b00011, 20);
        run_steady(5'b10100, 20);
        run_steady(5'b11111, 20);
        run_steady(5'b00001, 20);
        cur_req = "R9";
        do_reset(5'b11101, 1'b1);
        cur_req = "R3";
        run_steady(5'b11101, 10);
        run_steady(5'b00010, 30);

        cur_req = "R4";
        ratio_code = 5'b01100;
        for (int i = 0; i < 300; i++) begin
            if (i % 23 == 0) src_sel = ~src_sel;
            step(2'($urandom_range(0, 3)), 0, 0, 0);
        end

        cur_req = "R5";
        run_steady(5'b00000, 30);

        cur_req = "R6";
        ratio_code = 5'b00001;
        for (int i = 0; i < 250; i++)
            step(2'($urandom_range(0, 3)), ($urandom_range(0, 9) < 3), 0, 0);

        cur_req = "R7";
        ratio_code = 5'b00100;
        for (int i = 0; i < 250; i++)
            step(2'b11, 0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

        cur_req = "R8";
        for (int i = 0; i < 400; i++) begin
            if (i % 3 == 0) ratio_code = legal[$urandom_range(0, 8)];
            if (i % 7 == 0) src_sel = 1'($urandom_range(0, 1));
            step(2'($urandom_range(0, 3)), 0, 0, 0);
        end

        cur_req = "R9";
        do_reset(5'b00010, 1'b0);
        run_steady(5'b00010, 20);

        wait (sb.size() == 0);
        repeat (2) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule